// File: doc/BRIEF.md
# Serial DMA Channel Request/Grant Passer (Agent Side)

This block lets an expansion agent pass up to eight DMA channel requests to a host DMA controller over one request wire, and learn which channel the host has granted over one grant wire. Both wires are active-low and idle high. The block serialises the local request vector into a framed bitstream on the request pin. It also watches the grant pin for a framed channel number and turns it into a parallel channel index with a one-clock valid strobe.

The request encoder keeps a snapshot of the last vector it sent. When it is idle and the live vector differs from that snapshot, it captures the live vector and sends a frame. The frame is one low start bit, then one slot per channel, in ascending channel order, then at least one high clock. The grant decoder waits in an idle state for a low level. It then samples the next three clocks as the channel number, least significant bit first, and reports the result. A grant for a channel that is not currently requested is still reported, with an error flag.

Encoder states are `ENC_IDLE`, `ENC_SLOT` and `ENC_GAP`. The transitions are:
- IDLE→SLOT when the live vector differs from the snapshot.
- SLOT→SLOT while slots remain.
- SLOT→GAP after the last slot.
- GAP→IDLE always.

Decoder states are `DEC_IDLE` and `DEC_BITS`. The transitions are:
- IDLE→BITS when the grant pin is low.
- BITS→BITS while channel bits remain.
- BITS→IDLE on the last bit, which also raises the valid strobe.

Top module: `dma_chan_passer`

## Requirements
- R1: A request frame is one clock with `req_n` low (start), followed by NUM_CH one-clock slots carrying channels 0, 1, … NUM_CH-1 in that order.
- R2: In a slot, `req_n` is 1 when the channel's bit in the captured snapshot is 1 (requesting) and 0 when it is 0.
- R3: After the last slot, `req_n` is high for at least one clock before any new start bit, and it stays high whenever no frame is in progress.
- R4: A frame is launched, on the clock after `chan_req` is sampled, only while the encoder is idle and `chan_req` differs from the snapshot of the last frame sent. The snapshot is taken at launch. Changes during a frame are acted on only after that frame ends. A vector equal to the snapshot sends nothing.
- R5: After a start bit, the three following `grant_n` samples form the channel number, bit 0 first. The sequence 1,0,0 gives channel 1 and 0,1,1 gives channel 6.
- R6: `grant_valid` is high for exactly the one clock that follows the sampling of the last channel bit. The decoder is idle again in that clock, and a low `grant_n` in that clock starts a new grant frame.
- R7: While `rst_n` is low: `req_n` is high, `grant_valid` is low, the decoder is idle and the snapshot is all zeros.
- R8: `grant_err` is valid with `grant_valid`. It is 1 exactly when `chan_req` bit for the decoded channel was 0 on the clock the last grant bit was sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; one serial bit per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_req | input | NUM_CH | Live per-channel request vector, 1 = requesting |
| grant_n | input | 1 | Serial grant line from the host, idles high |
| req_n | output | 1 | Serial request line to the host, idles high |
| grant_valid | output | 1 | One-clock strobe: a grant frame was decoded |
| grant_chan | output | CH_W | Decoded channel number, valid with grant_valid |
| grant_err | output | 1 | Granted channel was not requesting, valid with grant_valid |

## Verification
The embedded assertions check, on every clock, the properties that hold in a single state:
- the snapshot stays frozen while a frame is on the wire;
- the pin is high after the gap state;
- the valid strobe never lasts two clocks and follows only from the bit-collecting state;
- the error flag agrees with the request vector sampled with the last bit.

Frame content, slot order and launch timing cannot be seen from one state, so the bench's behavioural model tracks them against the pin cycle by cycle. The model also covers the least-significant-bit-first decoding of grant streams, including frames that start right after a strobe and requests that change mid-frame.

// File: rtl/dma_pass_pkg.sv
package dma_pass_pkg;

    typedef enum logic [1:0] {
        ENC_IDLE = 2'd0,
        ENC_SLOT = 2'd1,
        ENC_GAP  = 2'd2
    } enc_state_t;

    typedef enum logic {
        DEC_IDLE = 1'b0,
        DEC_BITS = 1'b1
    } dec_state_t;

endpackage

// File: rtl/dma_req_encoder.sv
module dma_req_encoder
    import dma_pass_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] chan_req,
    output logic              req_n
);
    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CH - 1);

    enc_state_t        state, state_nx;
    logic [NUM_CH-1:0] snap, snap_nx;
    logic [IDX_W-1:0]  idx, idx_nx;
    logic              req_n_nx;
    logic              launch;

    assign launch = (state == ENC_IDLE) && (chan_req != snap);

    // next-state process
    always_comb begin
        state_nx = state;
        idx_nx   = idx;
        snap_nx  = snap;
        unique case (state)
            ENC_IDLE: begin
                if (launch) begin
                    snap_nx  = chan_req;
                    idx_nx   = '0;
                    state_nx = ENC_SLOT;
                end
            end
            ENC_SLOT: begin
                idx_nx = idx + 1'b1;
                if (idx == LAST_IDX) begin
                    state_nx = ENC_GAP;
                end
            end
            ENC_GAP: begin
                state_nx = ENC_IDLE;
            end
            default: begin
                state_nx = ENC_IDLE;
            end
        endcase
    end

    // output process
    always_comb begin
        req_n_nx = 1'b1;
        unique case (state)
            ENC_IDLE: req_n_nx = launch ? 1'b0 : 1'b1;
            ENC_SLOT: req_n_nx = snap[idx];
            ENC_GAP:  req_n_nx = 1'b1;
            default:  req_n_nx = 1'b1;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ENC_IDLE;
            idx   <= '0;
            snap  <= '0;
            req_n <= 1'b1;
        end else begin
            state <= state_nx;
            idx   <= idx_nx;
            snap  <= snap_nx;
            req_n <= req_n_nx;
        end
    end

    // R4: the captured vector cannot move while a frame is in flight
    a_r4_snap_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ENC_IDLE) |=> $stable(snap));

    // R3: the clock after the gap state always shows the line high
    a_r3_gap_high: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ENC_GAP) |=> req_n);

    // R1: a slot run always ends in the gap state, never straight in idle
    a_r1_slot_to_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ENC_SLOT && idx == LAST_IDX) |=> (state == ENC_GAP));

endmodule

// File: rtl/dma_grant_decoder.sv
module dma_grant_decoder
    import dma_pass_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      grant_n,
    input  logic [NUM_CH-1:0]                         chan_req,
    output logic                                      grant_valid,
    output logic [((NUM_CH > 1) ? $clog2(NUM_CH) : 1)-1:0] grant_chan,
    output logic                                      grant_err
);
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int CNT_W = (CH_W > 1) ? $clog2(CH_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(CH_W - 1);

    dec_state_t      state, state_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;
    logic [CH_W-1:0]  acc, acc_nx;
    logic             valid_nx;
    logic [CH_W-1:0]  chan_nx;
    logic             err_nx;

    // next-state process
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        acc_nx   = acc;
        unique case (state)
            DEC_IDLE: begin
                if (!grant_n) begin
                    state_nx = DEC_BITS;
                    cnt_nx   = '0;
                    acc_nx   = '0;
                end
            end
            DEC_BITS: begin
                acc_nx = acc | (CH_W'(grant_n) << cnt);
                cnt_nx = cnt + 1'b1;
                if (cnt == LAST_BIT) begin
                    state_nx = DEC_IDLE;
                end
            end
            default: state_nx = DEC_IDLE;
        endcase
    end

    // output process
    always_comb begin
        valid_nx = 1'b0;
        chan_nx  = grant_chan;
        err_nx   = grant_err;
        unique case (state)
            DEC_IDLE: ;
            DEC_BITS: begin
                if (cnt == LAST_BIT) begin
                    valid_nx = 1'b1;
                    chan_nx  = acc_nx;
                    err_nx   = ~chan_req[acc_nx];
                end
            end
            default: ;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= DEC_IDLE;
            cnt         <= '0;
            acc         <= '0;
            grant_valid <= 1'b0;
            grant_chan  <= '0;
            grant_err   <= 1'b0;
        end else begin
            state       <= state_nx;
            cnt         <= cnt_nx;
            acc         <= acc_nx;
            grant_valid <= valid_nx;
            grant_chan  <= chan_nx;
            grant_err   <= err_nx;
        end
    end

    // R6: the strobe lasts a single clock
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |=> !grant_valid);

    // R6: a strobe only follows a clock spent collecting bits
    a_r6_from_bits: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_valid) |-> ($past(state) == DEC_BITS));

    // R8: flag agrees with the request vector seen with the final bit
    a_r8_err_match: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_valid) |->
            (grant_err == (((($past(chan_req)) >> grant_chan) & NUM_CH'(1)) == '0)));

endmodule

// File: rtl/dma_chan_passer.sv
module dma_chan_passer #(
    parameter int NUM_CH = 8,
    parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] chan_req,
    input  logic              grant_n,
    output logic              req_n,
    output logic              grant_valid,
    output logic [CH_W-1:0]   grant_chan,
    output logic              grant_err
);

    dma_req_encoder #(
        .NUM_CH (NUM_CH)
    ) u_enc (
        .clk      (clk),
        .rst_n    (rst_n),
        .chan_req (chan_req),
        .req_n    (req_n)
    );

    dma_grant_decoder #(
        .NUM_CH (NUM_CH)
    ) u_dec (
        .clk         (clk),
        .rst_n       (rst_n),
        .grant_n     (grant_n),
        .chan_req    (chan_req),
        .grant_valid (grant_valid),
        .grant_chan  (grant_chan),
        .grant_err   (grant_err)
    );

    // R7: reset leaves both lines quiet
    a_r7_reset_quiet: assert property (@(posedge clk)
        $past(!rst_n) |-> (req_n && !grant_valid));

endmodule

// File: tb/dma_chan_passer_tb.sv
`timescale 1ns/1ps
module dma_chan_passer_tb;

    localparam int NUM_CH = 8;
    localparam int CH_W   = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NUM_CH-1:0] chan_req = '0;
    logic              grant_n = 1'b1;
    logic              req_n;
    logic              grant_valid;
    logic [CH_W-1:0]   grant_chan;
    logic              grant_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2 clk = ~clk;

    dma_chan_passer #(.NUM_CH(NUM_CH)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .chan_req    (chan_req),
        .grant_n     (grant_n),
        .req_n       (req_n),
        .grant_valid (grant_valid),
        .grant_chan  (grant_chan),
        .grant_err   (grant_err)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit     line_q[$];
    int     last_sent;
    int     gpos;
    int     gacc;
    bit     e_req   = 1;
    bit     e_valid = 0;
    int     e_chan  = 0;
    bit     e_err   = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            line_q.delete();
            last_sent = 0;
            gpos = -1;
            gacc = 0;
            e_req = 1;
            e_valid = 0;
        end else begin
            // request side
            if (line_q.size() == 0 && int'(chan_req) != last_sent) begin
                last_sent = int'(chan_req);
                line_q.push_back(1'b0);
                for (int i = 0; i < NUM_CH; i++) line_q.push_back(chan_req[i]);
                line_q.push_back(1'b1);
            end
            e_req = (line_q.size() != 0) ? line_q.pop_front() : 1'b1;
            // grant side
            e_valid = 0;
            if (gpos < 0) begin
                if (!grant_n) begin
                    gpos = 0;
                    gacc = 0;
                end
            end else begin
                gacc = gacc + (int'(grant_n) << gpos);
                gpos++;
                if (gpos == CH_W) begin
                    e_valid = 1;
                    e_chan  = gacc;
                    e_err   = !chan_req[gacc];
                    gpos    = -1;
                end
            end
        end
    end

    // per-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            if (!rst_n) begin
                check("R7 req_n in reset", req_n, 1);
                check("R7 grant_valid in reset", grant_valid, 0);
            end else begin
                check("R1/R2/R3 req_n line", req_n, e_req);
                check("R6 grant_valid", grant_valid, e_valid);
                if (e_valid) begin
                    check("R5 grant_chan", grant_chan, e_chan);
                    check("R8 grant_err", grant_err, e_err);
                end
            end
        end
    end

    // directed grant frame with explicit literal expectations
    task automatic send_grant(input int ch, input bit exp_err);
        @(negedge clk) grant_n = 1'b0;
        for (int b = 0; b < CH_W; b++) begin
            @(negedge clk) grant_n = ch[b];
        end
        @(negedge clk);
        check("R6 directed strobe", grant_valid, 1);
        check("R5 directed channel", grant_chan, ch);
        check("R8 directed error flag", grant_err, exp_err);
        grant_n = 1'b1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(200000 * 4);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        idle(5);
        rst_n = 1'b1;
        idle(4);                       // R4: zero vector equals snapshot, line stays high
        check("R4 no frame for unchanged vector", req_n, 1);

        chan_req = 8'h02;
        idle(14);
        send_grant(1, 1'b0);           // R5: bits 1,0,0 -> channel 1
        send_grant(6, 1'b1);           // R5: bits 0,1,1 -> 6; R8: not requested

        chan_req = 8'h81;              // R4: change mid-frame
        idle(3);
        chan_req = 8'h18;
        idle(25);
        chan_req = 8'h00;
        idle(12);
        chan_req = 8'h40;
        send_grant(6, 1'b0);
        idle(12);

        // mixed random phase: back-to-back grants and rapid request changes
        for (int c = 0; c < 3000; c++) begin
            @(negedge clk);
            if ($urandom_range(0, 9) == 0) chan_req = NUM_CH'($urandom);
            grant_n = ($urandom_range(0, 3) != 0);
        end
        grant_n = 1'b1;
        idle(20);

        // mid-run reset
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        chan_req = 8'hA5;
        idle(15);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule